// File: doc/BRIEF.md
# PHY Management Register File

This block models the sixteen 16-bit management registers of a 10/100 Ethernet PHY. A management controller reaches it through a parallel command port: a PHY address, a register index, write data, and a write strobe and a read strobe. The block answers only at its own PHY address. Read data is registered and appears one cycle after the read strobe. A separate link input drives the link-status bit and the partner-ability bits, so software sees the live link state.

The register set holds a control word, a status word, two identity words, a local-ability word and a link-partner word. The remaining ten slots are plain storage. The status and identity words cannot be written. Setting the top bit of the control word reloads the whole set with its reset values and does not store the written word. The link-dependent bits are then rebuilt from the current link input in the same cycle.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, index 0 reads 0x1000, index 1 reads 0x7848, index 2 reads 0x2000, index 3 reads 0x5c90, index 4 reads 0x01e1 and every other index below 16 reads 0x0000, all at PHY address 1 while the link input is low.
- R2: A read strobe loads `rdData` at the next rising edge. The value returned is the register contents before any write made in that same cycle.
- R3: A write at PHY address 1 to index 0 with bit 15 clear, or to any index from 4 to 15, stores the full 16-bit word, and a later read returns it.
- R4: Writes to index 1 (status), index 2 and index 3 (identity) leave those registers unchanged.
- R5: A write at PHY address 1 to index 0 with bit 15 set does not store the word. It returns every register to its R1 value.
- R6: When the link input rises, status bit 2 becomes 1 and bits 0x01e1 are ORed into index 5.
- R7: When the link input falls, status bit 2 becomes 0 and index 5 is ANDed with 0x01ff.
- R8: In the cycle of an R5 reload, status bit 2 and index 5 are recomputed from the live link input, using the R6 rule when it is high and the R7 rule when it is low.
- R9: A read at any PHY address other than 1 returns 0xffff. A write at any such address changes no register.
- R10: A write at PHY address 1 to an index of 16 or above changes no register, including the register whose low four index bits match. A read of such an index returns 0x0000.
- R11: While the read strobe is low, `rdData` holds its last value, and it is 0x0000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phyAddr | input | 5 | PHY address of the command |
| regIdx | input | 5 | Register index of the command |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| linkUp | input | 1 | Live link state, high when the link is up |
| rdData | output | 16 | Registered read data |

## Verification
Damage to a register's stored state stays hidden until that index is read. The bench therefore reads back every index it touches, one cycle after the strobe. A wrong link-edge tracker shows up as a status bit 2 or partner word that is wrong on the read right after the link toggles. A reload that skips the link recompute shows up only when the reload happens with the link high, so that case is driven on purpose. Writes to out-of-range indices and foreign addresses are followed by reads of the aliased slot, so that a stray store appears within two cycles.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int CTRL_IDX    = 0;
  localparam int STATUS_IDX  = 1;
  localparam int ID_HI_IDX   = 2;
  localparam int ID_LO_IDX   = 3;
  localparam int ADV_IDX     = 4;
  localparam int PARTNER_IDX = 5;

  localparam int SOFT_RST_BIT = 15;
  localparam int LINK_BIT     = 2;

  localparam logic [15:0] PARTNER_UP_SET    = 16'h01e1;
  localparam logic [15:0] PARTNER_DOWN_KEEP = 16'h01ff;
  localparam logic [15:0] FOREIGN_DATA      = 16'hffff;
  localparam logic [15:0] EMPTY_DATA        = 16'h0000;

  // strobes from control to datapath
  typedef struct packed {
    logic store;      // write the addressed slot
    logic softRst;    // reload all slots
    logic linkApply;  // recompute link bits
    logic linkVal;    // link level to apply
    logic rdLoad;     // capture read data
    logic rdForeign;  // answer for another PHY
    logic rdOutRange; // index beyond the set
  } mgmtCmdT;

  function automatic logic [15:0] resetValue(input int idx);
    case (idx)
      CTRL_IDX:   return 16'h1000;
      STATUS_IDX: return 16'h7848;
      ID_HI_IDX:  return 16'h2000;
      ID_LO_IDX:  return 16'h5c90;
      ADV_IDX:    return 16'h01e1;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic isReadOnly(input int idx);
    return (idx == STATUS_IDX) || (idx == ID_HI_IDX) || (idx == ID_LO_IDX);
  endfunction

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int MY_PHY   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              linkUp,
  output mgmtCmdT           cmd
);

  localparam logic [PHY_W-1:0] SELF_ADDR = PHY_W'(MY_PHY);
  localparam logic [REG_W-1:0] IDX_LIMIT = REG_W'(NUM_REGS);

  logic linkPrev;
  logic selected;
  logic inRange;
  logic isCtrl;
  logic roSlot;
  logic wrHit;

  always_comb begin
    selected = (phyAddr == SELF_ADDR);
    inRange  = (regIdx < IDX_LIMIT);
    isCtrl   = (regIdx == REG_W'(CTRL_IDX));
    roSlot   = isReadOnly(int'(regIdx));
    wrHit    = wrEn && selected && inRange;
  end

  always_comb begin
    cmd.softRst    = wrHit && isCtrl && wrData[SOFT_RST_BIT];
    cmd.store      = wrHit && !roSlot && !(isCtrl && wrData[SOFT_RST_BIT]);
    cmd.linkApply  = cmd.softRst || (linkUp != linkPrev);
    cmd.linkVal    = linkUp;
    cmd.rdLoad     = rdEn;
    cmd.rdForeign  = !selected;
    cmd.rdOutRange = !inRange;
  end

  // link edge tracker; reset level matches status reset value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkPrev <= 1'b0;
    else       linkPrev <= linkUp;
  end

endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  mgmtCmdT                          cmd,
  input  logic [REG_W-1:0]                 regIdx,
  input  logic [DATA_W-1:0]                wrData,
  output logic [DATA_W-1:0]                rdData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regSnap
);

  localparam int SLOT_W = $clog2(NUM_REGS);

  logic [SLOT_W-1:0] slot;
  assign slot = regIdx[SLOT_W-1:0];

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(resetValue(i));
    logic [DATA_W-1:0] baseVal;
    logic [DATA_W-1:0] nextVal;

    always_comb begin
      if (cmd.softRst)
        baseVal = RST_VAL;
      else if (cmd.store && (slot == SLOT_W'(i)))
        baseVal = wrData;
      else
        baseVal = regQ[i];
    end

    if (i == STATUS_IDX) begin : g_status
      always_comb begin
        nextVal = baseVal;
        if (cmd.linkApply) nextVal[LINK_BIT] = cmd.linkVal;
      end
    end else if (i == PARTNER_IDX) begin : g_partner
      always_comb begin
        nextVal = baseVal;
        if (cmd.linkApply)
          nextVal = cmd.linkVal ? (baseVal | PARTNER_UP_SET)
                                : (baseVal & PARTNER_DOWN_KEEP);
      end
    end else begin : g_plain
      assign nextVal = baseVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[i] <= RST_VAL;
      else       regQ[i] <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= EMPTY_DATA;
    else if (cmd.rdLoad) begin
      if (cmd.rdForeign)       rdData <= FOREIGN_DATA;
      else if (cmd.rdOutRange) rdData <= EMPTY_DATA;
      else                     rdData <= regQ[slot];
    end
  end

  assign regSnap = regQ;

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int MY_PHY   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              linkUp,
  output logic [DATA_W-1:0] rdData
);

  mgmtCmdT cmd;
  logic [NUM_REGS-1:0][DATA_W-1:0] regSnap;

  phy_mgmt_ctrl #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .NUM_REGS(NUM_REGS), .MY_PHY(MY_PHY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .regIdx(regIdx),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .linkUp(linkUp),
    .cmd(cmd)
  );

  phy_mgmt_dp #(
    .REG_W(REG_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .regSnap(regSnap)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int MY_PHY   = 1
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [PHY_W-1:0]                phyAddr,
  input logic [REG_W-1:0]                regIdx,
  input logic [DATA_W-1:0]               wrData,
  input logic                            wrEn,
  input logic                            rdEn,
  input logic                            linkUp,
  input logic [DATA_W-1:0]               rdData,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regSnap
);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R9
  foreign_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && phyAddr != PHY_W'(MY_PHY)) |=> rdData == 16'hffff);

  // R6
  link_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |=> regSnap[1][2]);

  // R7
  link_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkUp) |=> !regSnap[1][2]);

  // R4
  ro_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSnap[1] & 16'hfffb) == 16'h7848);

  // R4
  ro_ident_chk: assert property (@(posedge clk) disable iff (!rstN)
    regSnap[2] == 16'h2000 && regSnap[3] == 16'h5c90);

  // R5
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && phyAddr == PHY_W'(MY_PHY) && regIdx == '0 && wrData[15])
      |=> (regSnap[0] == 16'h1000 && regSnap[4] == 16'h01e1));

  // R10
  high_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regIdx >= REG_W'(NUM_REGS))
      |=> ($stable(regSnap[0]) && $stable(regSnap[NUM_REGS-1])));

endmodule

bind phy_mgmt_regs phy_mgmt_chk #(
  .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W),
  .NUM_REGS(NUM_REGS), .MY_PHY(MY_PHY)
) u_chk (
  .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .regIdx(regIdx),
  .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .linkUp(linkUp),
  .rdData(rdData), .regSnap(regSnap)
);

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regIdx = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        linkUp = 1'b0;
  logic [15:0] rdData;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  phy_mgmt_regs u_phy_mgmt_regs (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .regIdx(regIdx),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .linkUp(linkUp),
    .rdData(rdData)
  );

  typedef struct packed {
    logic        isWr;
    logic [4:0]  phy;
    logic [4:0]  idx;
    logic [15:0] data;   // write data or expected read value
    logic [3:0]  req;
  } vecT;

  localparam int NVEC = 30;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 5'd1, 5'd0,  16'h1000, 4'd1},   // R1
    '{1'b0, 5'd1, 5'd1,  16'h7848, 4'd1},
    '{1'b0, 5'd1, 5'd2,  16'h2000, 4'd1},
    '{1'b0, 5'd1, 5'd3,  16'h5c90, 4'd1},
    '{1'b0, 5'd1, 5'd4,  16'h01e1, 4'd1},
    '{1'b0, 5'd1, 5'd5,  16'h0000, 4'd1},
    '{1'b0, 5'd1, 5'd9,  16'h0000, 4'd1},
    '{1'b1, 5'd1, 5'd4,  16'habcd, 4'd3},   // R3
    '{1'b0, 5'd1, 5'd4,  16'habcd, 4'd3},
    '{1'b1, 5'd1, 5'd1,  16'hffff, 4'd4},   // R4
    '{1'b0, 5'd1, 5'd1,  16'h7848, 4'd4},
    '{1'b1, 5'd1, 5'd2,  16'h1234, 4'd4},
    '{1'b0, 5'd1, 5'd2,  16'h2000, 4'd4},
    '{1'b1, 5'd1, 5'd3,  16'h1234, 4'd4},
    '{1'b0, 5'd1, 5'd3,  16'h5c90, 4'd4},
    '{1'b1, 5'd1, 5'd0,  16'h3100, 4'd3},
    '{1'b0, 5'd1, 5'd0,  16'h3100, 4'd3},
    '{1'b1, 5'd2, 5'd4,  16'h5555, 4'd9},   // R9
    '{1'b0, 5'd1, 5'd4,  16'habcd, 4'd9},
    '{1'b0, 5'd2, 5'd0,  16'hffff, 4'd9},
    '{1'b0, 5'd0, 5'd4,  16'hffff, 4'd9},
    '{1'b1, 5'd1, 5'd15, 16'hbeef, 4'd3},
    '{1'b0, 5'd1, 5'd15, 16'hbeef, 4'd3},
    '{1'b1, 5'd1, 5'd16, 16'h1111, 4'd10},  // R10
    '{1'b0, 5'd1, 5'd0,  16'h3100, 4'd10},
    '{1'b1, 5'd1, 5'd31, 16'h2222, 4'd10},
    '{1'b0, 5'd1, 5'd15, 16'hbeef, 4'd10},
    '{1'b0, 5'd1, 5'd16, 16'h0000, 4'd10},
    '{1'b1, 5'd1, 5'd5,  16'hfe00, 4'd3},
    '{1'b0, 5'd1, 5'd5,  16'hfe00, 4'd3}
  };

  task automatic check(input string what, input logic [15:0] got,
                       input logic [15:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", what, got, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] p, input logic [4:0] i,
                         input logic [15:0] d);
    @(negedge clk);
    phyAddr = p; regIdx = i; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] p, input logic [4:0] i,
                        output logic [15:0] v);
    @(negedge clk);
    phyAddr = p; regIdx = i; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic setLink(input logic v);
    @(negedge clk);
    linkUp = v;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             checkCnt, failCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 rdData after reset", rdData, 16'h0000);

    for (int k = 0; k < NVEC; k++) begin
      if (VECS[k].isWr) doWrite(VECS[k].phy, VECS[k].idx, VECS[k].data);
      else begin
        doRead(VECS[k].phy, VECS[k].idx, v);
        check($sformatf("R%0d table row %0d", VECS[k].req, k), v, VECS[k].data);
      end
    end

    // R6: link rises, partner fe00 gains 01e1
    setLink(1'b1);
    doRead(5'd1, 5'd1, v); check("R6 status link bit up", v, 16'h784c);
    doRead(5'd1, 5'd5, v); check("R6 partner on link up", v, 16'hffe1);

    // R7: link falls, partner masked to 01ff
    setLink(1'b0);
    doRead(5'd1, 5'd1, v); check("R7 status link bit down", v, 16'h7848);
    doRead(5'd1, 5'd5, v); check("R7 partner on link down", v, 16'h01e1);

    // R5 and R8: reload with link high
    setLink(1'b1);
    doWrite(5'd1, 5'd7, 16'h1234);
    doWrite(5'd1, 5'd0, 16'h8000);
    doRead(5'd1, 5'd0, v); check("R5 control after reload", v, 16'h1000);
    doRead(5'd1, 5'd7, v); check("R5 plain slot after reload", v, 16'h0000);
    doRead(5'd1, 5'd15, v); check("R5 top slot after reload", v, 16'h0000);
    doRead(5'd1, 5'd4, v); check("R5 advert after reload", v, 16'h01e1);
    doRead(5'd1, 5'd1, v); check("R8 status after reload link up", v, 16'h784c);
    doRead(5'd1, 5'd5, v); check("R8 partner after reload link up", v, 16'h01e1);

    // R8: reload with link low
    doWrite(5'd1, 5'd5, 16'hffff);
    setLink(1'b0);
    doWrite(5'd1, 5'd0, 16'h8123);
    doRead(5'd1, 5'd1, v); check("R8 status after reload link down", v, 16'h7848);
    doRead(5'd1, 5'd5, v); check("R8 partner after reload link down", v, 16'h0000);
    doRead(5'd1, 5'd0, v); check("R5 word not stored", v, 16'h1000);

    // R2: read and write together return the old value
    @(negedge clk);
    phyAddr = 5'd1; regIdx = 5'd4; wrData = 16'h7777; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R2 read returns pre-write value", rdData, 16'h01e1);
    doRead(5'd1, 5'd4, v); check("R2 next read sees write", v, 16'h7777);

    // R11: hold while rdEn low
    doRead(5'd1, 5'd3, v);
    @(negedge clk);
    phyAddr = 5'd2; regIdx = 5'd0; wrData = 16'h4444;
    repeat (3) @(negedge clk);
    check("R11 rdData holds", rdData, 16'h5c90);

    // R9: foreign write leaves slot alone
    doWrite(5'd3, 5'd6, 16'h9999);
    doRead(5'd1, 5'd6, v); check("R9 foreign write ignored", v, 16'h0000);

    // R1: hard reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R11 rdData cleared by reset", rdData, 16'h0000);
    rstN = 1'b1;
    doRead(5'd1, 5'd4, v); check("R1 advert after hard reset", v, 16'h01e1);
    doRead(5'd1, 5'd0, v); check("R1 control after hard reset", v, 16'h1000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule